// File: doc/BRIEF.md
# Masked Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from around a board and presents the processor with a single 4-bit encoded interrupt level. Each request line is first brought into the clock domain by a two-flop synchronizer. It then lands in a 16-bit monitor word at a bit position that is fixed per source. The monitor bit follows the line's level and never latches.

Software writes a 16-bit enable mask. A source is pending when both its monitor bit and the matching mask bit are set. Each source also has a fixed priority number, 0 to 12. The smallest pending number wins. That number is inverted (XOR 15) and driven out as the level, so a quiet block drives 0 and the most urgent source drives 15.

A small register window on a 16-bit bus holds the mask, a general-purpose output port, a fixed version word and a power-off trigger. The power-off trigger is a single-cycle request pulse.

Top module: `irq_level_enc`

## Requirements
- R1: Request line `irq_i[p]` is the source of priority p. It sets monitor bit B(p) while it is high and clears that bit while it is low. B is: p0→11, p1→9, p2→8, p3→12, p4→10, p5→6, p6→5, p7→4, p8→7, p9→14, p10→13, p11→0, p12→15. Monitor bits 1, 2 and 3 stay 0.
- R2: A source counts as pending only when its monitor bit B(p) and mask bit B(p) are both 1. Mask bits with no source (1, 2, 3) have no effect.
- R3: Among pending sources the smallest priority p wins, and `lvl_o` = p XOR 15. With nothing pending, `lvl_o` = 0.
- R4: `lvl_o` is registered. A change on `irq_i` first shows on `lvl_o` three clock edges later (two synchronizer edges plus the output register). A mask write shows one edge after the write is captured.
- R5: Byte offset 0x00 is the mask register, readable and writable.
- R6: Offset 0x36 is an output port register. It is readable and writable, and it drives `port_o` directly.
- R7: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R8: Offset 0x30 reads 0. A write there with `wdata_i[0]`=1 gives `off_req_o`=1 for exactly the cycle after the write edge. A write with bit 0 clear gives no pulse.
- R9: Reads of any other offset return 0. Writes to any other offset leave the mask and the port unchanged.
- R10: A read strobe captured at an edge gives `rvalid_o`=1 with its data on `rdata_o` after that edge, for one cycle.
- R11: While `rst_ni` is low, the mask, the port, the monitor word and `lvl_o` are cleared, and `off_req_o` and `rvalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 13 | Asynchronous level request lines, index = priority |
| addr_i | input | 6 | Byte offset in the register window |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| lvl_o | output | 4 | Encoded interrupt level (0 = idle) |
| off_req_o | output | 1 | One-cycle power-off request |
| port_o | output | 16 | General output port |

## Verification
The bench sweeps every one of the 8192 request patterns under a full mask and under a sparse mask. A swapped bit-to-priority entry would give the wrong level on single-source patterns. A largest-wins encoder would fail as soon as two sources tie. A missing XOR would make the idle level read 15.

Timing is probed cycle by cycle. A design that decodes the mask without a register, or that drops a synchronizer stage, would move the level one cycle early. The probes also cover the unmapped mask bits, and writes to the version register and to offsets outside the map, which must leave the mask and the port untouched. The power-off trigger is checked to pulse for a single cycle, and only when bit 0 is set.

// File: rtl/irq_level_enc_pkg.sv
package irq_level_enc_pkg;
  localparam int NUM_SRC  = 13;
  localparam int LVL_W    = 4;
  localparam int OFF_MASK = 'h00;
  localparam int OFF_PWR  = 'h30;
  localparam int OFF_VER  = 'h32;
  localparam int OFF_PORT = 'h36;

  // status/mask bit position of the source with priority p
  function automatic logic [3:0] src_bit(input int p);
    case (p)
      0:  src_bit = 4'd11;
      1:  src_bit = 4'd9;
      2:  src_bit = 4'd8;
      3:  src_bit = 4'd12;
      4:  src_bit = 4'd10;
      5:  src_bit = 4'd6;
      6:  src_bit = 4'd5;
      7:  src_bit = 4'd4;
      8:  src_bit = 4'd7;
      9:  src_bit = 4'd14;
      10: src_bit = 4'd13;
      11: src_bit = 4'd0;
      default: src_bit = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 13,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_level_enc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mon_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [LVL_W-1:0]  lvl_o
);
  localparam logic [LVL_W-1:0] IDLE = '1;

  logic [DATA_W-1:0] pend;
  logic [LVL_W-1:0]  win;
  logic [LVL_W-1:0]  lvl_q;

  assign pend = mon_i & mask_i;

  // scan downward so the smallest pending priority is assigned last
  always_comb begin
    win = IDLE;
    for (int p = NUM_SRC-1; p >= 0; p--) begin
      if (pend[src_bit(p)]) win = LVL_W'(p);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else lvl_q <= win ^ IDLE;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_level_enc_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 6,
  parameter logic [15:0] VERSION = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] port_o,
  output logic              off_req_o
);
  logic [DATA_W-1:0] mask_q, port_q, rdata_q, rd_mux;
  logic              rvalid_q, off_q;
  logic              hit_mask, hit_pwr, hit_ver, hit_port;

  assign hit_mask = addr_i == ADDR_W'(OFF_MASK);
  assign hit_pwr  = addr_i == ADDR_W'(OFF_PWR);
  assign hit_ver  = addr_i == ADDR_W'(OFF_VER);
  assign hit_port = addr_i == ADDR_W'(OFF_PORT);

  always_comb begin
    rd_mux = '0;
    if (hit_mask) rd_mux = mask_q;
    if (hit_port) rd_mux = port_q;
    if (hit_ver)  rd_mux = DATA_W'(VERSION);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      port_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      if (wr_i && hit_mask) mask_q <= wdata_i;
      if (wr_i && hit_port) port_q <= wdata_i;
      off_q    <= wr_i && hit_pwr && wdata_i[0];
      rvalid_q <= rd_i;
      rdata_q  <= rd_i ? rd_mux : '0;
    end
  end

  assign mask_o    = mask_q;
  assign port_o    = port_q;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign off_req_o = off_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_level_enc_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          ADDR_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VERSION     = 16'h0010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic               off_req_o,
  output logic [DATA_W-1:0]  port_o
);
  logic [NUM_SRC-1:0] irq_s;
  logic [DATA_W-1:0]  mon_w;
  logic [DATA_W-1:0]  mask_q;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_s)
  );

  // scatter synchronized lines into monitor word
  always_comb begin
    mon_w = '0;
    for (int p = 0; p < NUM_SRC; p++) mon_w[src_bit(p)] = irq_s[p];
  end

  irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .mask_o   (mask_q),
    .port_o   (port_o),
    .off_req_o(off_req_o)
  );

  irq_prio_enc #(.DATA_W(DATA_W)) u_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mon_i (mon_w),
    .mask_i(mask_q),
    .lvl_o (lvl_o)
  );
endmodule

// File: rtl/irq_level_enc_chk.sv
module irq_level_enc_chk
  import irq_level_enc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [LVL_W-1:0]  lvl_o,
  input logic              off_req_o,
  input logic [DATA_W-1:0] port_o,
  input logic [DATA_W-1:0] mon_w,
  input logic [DATA_W-1:0] mask_q
);
  // R3
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mon_w & mask_q) == '0) |=> (lvl_o == '0));

  // R3
  top_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_w[11] && mask_q[11]) |=> (lvl_o == '1));

  // R8
  off_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |-> $past(wr_i && addr_i == ADDR_W'(OFF_PWR) && wdata_i[0]));

  // R10
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  // R7
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(OFF_VER)) |=> (rdata_o == DATA_W'(16'h0010)));

  // R6
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(OFF_PORT)) |=> $stable(port_o));

  // R1
  unmapped_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_w[3:1] == 3'b000);
endmodule

bind irq_level_enc irq_level_enc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .lvl_o    (lvl_o),
  .off_req_o(off_req_o),
  .port_o   (port_o),
  .mon_w    (mon_w),
  .mask_q   (mask_q)
);

// File: tb/irq_level_enc_bench.sv
module irq_level_enc_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 11;
  localparam int BITMAP [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  typedef struct packed {
    logic [12:0] irq;
    logic [15:0] mask;
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{13'h0000, 16'hFFFF, 4'h0},
    '{13'h0001, 16'hFFFF, 4'hF},
    '{13'h1000, 16'hFFFF, 4'h3},
    '{13'h1001, 16'h8000, 4'h3},
    '{13'h0220, 16'hFFFF, 4'hA},
    '{13'h0220, 16'hFFBF, 4'h6},
    '{13'h1FFF, 16'h0001, 4'h4},
    '{13'h1FFF, 16'h000E, 4'h0},
    '{13'h0088, 16'h1010, 4'hC},
    '{13'h0100, 16'h0080, 4'h7},
    '{13'h0006, 16'h0100, 4'hD}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] irq = '0;
  logic [5:0]  addr = '0;
  logic        wr = 0, rd = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic [3:0]  lvl;
  logic        off_req;
  logic [15:0] port;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] got;

  always #(CLK_P/2) clk = ~clk;

  irq_level_enc u_irq_level_enc (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .lvl_o(lvl),
    .off_req_o(off_req), .port_o(port)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<=200000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [12:0] v, input logic [15:0] m);
    for (int p = 0; p < 13; p++)
      if (v[p] && m[BITMAP[p]]) return 4'(p) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
    checks++;
    if (!rvalid) begin
      errors++;
      $display("FAIL R10: rvalid act=0 exp=1");
    end
    d = rdata;
  endtask

  task automatic set_irq(input logic [12:0] v);
    @(negedge clk); irq = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 lvl", 32'(lvl), 0);
    check("R11 port", 32'(port), 0);
    check("R11 off", 32'(off_req), 0);
    check("R11 rvalid", 32'(rvalid), 0);
    rst_n = 1;
    bus_rd(6'h00, got); check("R11 mask", 32'(got), 0);
    @(negedge clk); check("R10 rvalid drop", 32'(rvalid), 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(6'h00, VECS[i].mask);
      set_irq(VECS[i].irq);
      check("R3 vec", 32'(lvl), 32'(VECS[i].exp));
    end

    // R1 each source alone
    bus_wr(6'h00, 16'hFFFF);
    for (int p = 0; p < 13; p++) begin
      set_irq(13'(1 << p));
      check("R1 single", 32'(lvl), 32'(4'(p) ^ 4'hF));
    end

    // R3 all combinations under two masks; R2 gating
    for (int k = 0; k < 2; k++) begin
      logic [15:0] m;
      m = (k == 0) ? 16'hFFFF : 16'h5A3C;
      bus_wr(6'h00, m);
      for (int v = 0; v < 8192; v++) begin
        set_irq(13'(v));
        check(k == 0 ? "R3 sweep" : "R2 sweep", 32'(lvl), 32'(model(13'(v), m)));
      end
    end

    // R4 input latency: three edges
    bus_wr(6'h00, 16'hFFFF);
    set_irq(13'h0000);
    @(negedge clk); irq = 13'h0010;
    @(negedge clk); check("R4 irq edge1", 32'(lvl), 0);
    @(negedge clk); check("R4 irq edge2", 32'(lvl), 0);
    @(negedge clk); check("R4 irq edge3", 32'(lvl), 32'hB);

    // R4 mask latency: one edge after capture
    bus_wr(6'h00, 16'h0000);
    @(negedge clk); check("R2 masked", 32'(lvl), 0);
    bus_wr(6'h00, 16'h0400);
    check("R4 mask same", 32'(lvl), 0);
    @(negedge clk); check("R4 mask next", 32'(lvl), 32'hB);
    bus_rd(6'h00, got); check("R5 mask rd", 32'(got), 32'h0400);

    // R6 port
    bus_wr(6'h36, 16'hBEEF);
    check("R6 port_o", 32'(port), 32'hBEEF);
    bus_rd(6'h36, got); check("R6 port rd", 32'(got), 32'hBEEF);

    // R7 version
    bus_rd(6'h32, got); check("R7 ver", 32'(got), 32'h0010);
    bus_wr(6'h32, 16'hFFFF);
    bus_rd(6'h32, got); check("R7 ver after wr", 32'(got), 32'h0010);
    bus_rd(6'h00, got); check("R7 mask kept", 32'(got), 32'h0400);

    // R8 power off
    @(negedge clk); addr = 6'h30; wdata = 16'h0001; wr = 1;
    @(negedge clk); wr = 0; check("R8 pulse", 32'(off_req), 1);
    @(negedge clk); check("R8 pulse end", 32'(off_req), 0);
    @(negedge clk); addr = 6'h30; wdata = 16'hFFFE; wr = 1;
    @(negedge clk); wr = 0; check("R8 no pulse", 32'(off_req), 0);
    bus_rd(6'h30, got); check("R8 read", 32'(got), 0);

    // R9 unlisted offsets
    bus_wr(6'h02, 16'hFFFF);
    bus_wr(6'h34, 16'h1234);
    bus_wr(6'h3E, 16'h5555);
    bus_rd(6'h00, got); check("R9 mask kept", 32'(got), 32'h0400);
    check("R9 port kept", 32'(port), 32'hBEEF);
    bus_rd(6'h02, got); check("R9 rd 02", 32'(got), 0);
    bus_rd(6'h34, got); check("R9 rd 34", 32'(got), 0);
    @(negedge clk); check("R9 lvl kept", 32'(lvl), 32'hB);

    // R11 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R11 lvl mid", 32'(lvl), 0);
    check("R11 port mid", 32'(port), 0);
    rst_n = 1; irq = '0;
    bus_rd(6'h00, got); check("R11 mask mid", 32'(got), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule